// File: doc/BRIEF.md
# Interleaved-ADC Timing Skew Estimator

This block estimates how far one channel of an NCH-way time-interleaved ADC samples early or late. An extra reference converter is clocked on the same phase as the channel under test, so with no skew the two take the same sample. Once per interleave period (one frame) the block takes two absolute differences. The first is the step from the preceding channel to the channel under test. The second is the step from the preceding channel to the reference.

Over a window of 2^WIN_LOG2 counted frames the block sums both differences. It then divides the first sum by the second in a multi-cycle restoring divider. The result is one minus that ratio, as a signed fixed-point value. A channel that samples late shows a larger step from its predecessor than the reference does, so a late channel gives a negative result. Multiplying the result by the sampling period gives the skew in time. A start pulse latches the channel index and begins a fresh window.

Top module: `tiskew_estimator`

## Requirements
- R1: After reset, est_valid and est_err are 0 and est_value is 0.
- R2: For a selected index s greater than 0, the frame adds |lane s − lane s−1| to the test sum and |ref_code − lane s−1| to the reference sum. Lane i of ch_codes occupies bits [i*CODE_W +: CODE_W], and all codes are unsigned.
- R3: For index 0, the predecessor is lane NCH−1 of the previous accepted frame since start. The first frame after a start with index 0 adds nothing and does not count.
- R4: Only frames with frame_valid high during an open window count. Frames outside a window, and cycles with frame_valid low, change neither sum nor the result.
- R5: The result is 2^FRAC_W − floor(test_sum·2^FRAC_W / ref_sum), in two's complement on OUT_W bits with FRAC_W fraction bits. Equal sums give 0.
- R6: est_valid is a single-cycle pulse and comes at most DVD_W+4 clock cycles after the clock edge that takes the window's last counted frame. No pulse comes otherwise.
- R7: If the reference sum is 0 at window end, the pulse carries est_value 0 and est_err 1. Otherwise est_err is 0.
- R8: start clears both sums and the frame count and latches sel_idx. A window or division in progress is dropped, and it produces no pulse.
- R9: When the test channel's steps exceed the reference steps, the result is negative.
- R10: Sums never wrap. A full window of full-scale steps (255 against a reference step of 1) gives the exact R5 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new window, latch sel_idx |
| sel_idx | input | $clog2(NCH) | Index of channel under test |
| frame_valid | input | 1 | One interleave period of codes is present |
| ch_codes | input | NCH*CODE_W | All channel codes of the frame, lane i at [i*CODE_W +: CODE_W] |
| ref_code | input | CODE_W | Reference converter code for the frame |
| est_valid | output | 1 | One-cycle result strobe |
| est_value | output | CODE_W+WIN_LOG2+FRAC_W+1 | Signed skew estimate, FRAC_W fraction bits |
| est_err | output | 1 | Reference sum was zero |

## Verification
The bench checks the wrap-around predecessor for index 0. A design that used the same frame's last lane, or counted the first frame, would give a wrong quotient. It feeds a zero reference sum, where a naive divider would return all ones instead of flagging the error. It restarts during a division, and a design that let the stale result escape would pulse at a time the model does not expect. It also sends full-scale windows, so truncated sums or a short quotient show up as a wrong large negative value. Equal sums must give exactly zero, and frames sent outside a window must leave the next result untouched.

// File: rtl/tiskew_pkg.sv
package tiskew_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_LOAD = 2'd2,
      ST_DIV  = 2'd3
   } est_state_t;
endpackage

// File: rtl/tiskew_lane_pick.sv
module tiskew_lane_pick #(
   parameter int CODE_W = 8,
   parameter int NCH    = 4,
   localparam int IDX_W = $clog2(NCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    cap,
   input  logic [IDX_W-1:0]        sel,
   input  logic [NCH*CODE_W-1:0]   ch_codes,
   output logic [CODE_W-1:0]       cur,
   output logic [CODE_W-1:0]       pred,
   output logic                    usable
);
   logic [CODE_W-1:0] lanes [NCH];
   logic [CODE_W-1:0] last_q;
   logic              have_q;
   logic [IDX_W-1:0]  pidx;

   for (genvar g = 0; g < NCH; g++) begin : g_unpack
      assign lanes[g] = ch_codes[g*CODE_W +: CODE_W];
   end

   assign pidx   = sel - 1'b1;
   assign cur    = lanes[sel];
   assign pred   = (sel == '0) ? last_q : lanes[pidx];
   assign usable = (sel != '0) || have_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         last_q <= '0;
         have_q <= 1'b0;
      end else if (cap) begin
         last_q <= lanes[NCH-1];
         have_q <= 1'b1;
      end
   end

   AST_WRAP_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr) |=> (sel != '0 || !usable)) else $error("wrap predecessor used without history"); // R3
endmodule

// File: rtl/tiskew_accum.sv
module tiskew_accum #(
   parameter int CODE_W   = 8,
   parameter int WIN_LOG2 = 4,
   localparam int SUM_W   = CODE_W + WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic [CODE_W-1:0] cur,
   input  logic [CODE_W-1:0] pred,
   input  logic [CODE_W-1:0] refc,
   output logic [SUM_W-1:0]  sum_test,
   output logic [SUM_W-1:0]  sum_ref,
   output logic              win_last
);
   logic [CODE_W-1:0]   d_test, d_ref;
   logic [WIN_LOG2-1:0] cnt_q;

   always_comb begin
      d_test = (cur  >= pred) ? (cur  - pred) : (pred - cur);
      d_ref  = (refc >= pred) ? (refc - pred) : (pred - refc);
   end

   assign win_last = add && (cnt_q == {WIN_LOG2{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sum_test <= '0;
         sum_ref  <= '0;
         cnt_q    <= '0;
      end else if (add) begin
         sum_test <= sum_test + SUM_W'(d_test);
         sum_ref  <= sum_ref  + SUM_W'(d_ref);
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (add && !clr) |=> (sum_test >= $past(sum_test) && sum_ref >= $past(sum_ref))) else $error("sum wrapped"); // R10
   AST_CLEAR_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum_test == '0 && sum_ref == '0)) else $error("sums not cleared"); // R8
endmodule

// File: rtl/tiskew_divider.sv
module tiskew_divider #(
   parameter int DVD_W = 24,
   parameter int DSR_W = 12,
   localparam int CNT_W = $clog2(DVD_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DSR_W-1:0] divisor,
   output logic [DVD_W-1:0] quot,
   output logic             done
);
   logic [DSR_W:0]   rem_q, rem_sh;
   logic [DSR_W-1:0] dsr_q;
   logic [CNT_W-1:0] step_q;
   logic             busy_q;
   logic             fits;

   assign rem_sh = {rem_q[DSR_W-1:0], quot[DVD_W-1]};
   assign fits   = rem_sh >= {1'b0, dsr_q};

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         rem_q  <= '0;
         dsr_q  <= '0;
         quot   <= '0;
         step_q <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            rem_q  <= '0;
            dsr_q  <= divisor;
            quot   <= dividend;
            step_q <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q  <= fits ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
            quot   <= {quot[DVD_W-2:0], fits};
            step_q <= step_q + 1'b1;
            if (step_q == CNT_W'(DVD_W - 1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rem_q < {1'b0, dsr_q})) else $error("remainder out of range"); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than a cycle"); // R6
endmodule

// File: rtl/tiskew_estimator.sv
module tiskew_estimator #(
   parameter int CODE_W   = 8,
   parameter int NCH      = 4,
   parameter int WIN_LOG2 = 4,
   parameter int FRAC_W   = 12,
   localparam int IDX_W   = $clog2(NCH),
   localparam int SUM_W   = CODE_W + WIN_LOG2,
   localparam int DVD_W   = SUM_W + FRAC_W,
   localparam int OUT_W   = DVD_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [IDX_W-1:0]      sel_idx,
   input  logic                  frame_valid,
   input  logic [NCH*CODE_W-1:0] ch_codes,
   input  logic [CODE_W-1:0]     ref_code,
   output logic                  est_valid,
   output logic [OUT_W-1:0]      est_value,
   output logic                  est_err
);
   import tiskew_pkg::*;

   if (NCH < 2 || (1 << IDX_W) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (CODE_W < 2 || WIN_LOG2 < 1 || FRAC_W < 1) begin : g_bad_width
      $error("width parameters out of range");
   end

   localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << FRAC_W;

   est_state_t        state_q;
   logic [IDX_W-1:0]  sel_q;
   logic [CODE_W-1:0] cur, pred;
   logic              usable, cap, add, win_last, div_go, div_done;
   logic [SUM_W-1:0]  sum_test, sum_ref;
   logic [DVD_W-1:0]  quot;

   assign cap    = (state_q == ST_ACC) && frame_valid && !start;
   assign add    = cap && usable;
   assign div_go = (state_q == ST_LOAD) && (sum_ref != '0) && !start;

   tiskew_lane_pick #(.CODE_W(CODE_W), .NCH(NCH)) i_pick (
      .clk(clk), .rst_n(rst_n), .clr(start), .cap(cap), .sel(sel_q),
      .ch_codes(ch_codes), .cur(cur), .pred(pred), .usable(usable)
   );

   tiskew_accum #(.CODE_W(CODE_W), .WIN_LOG2(WIN_LOG2)) i_acc (
      .clk(clk), .rst_n(rst_n), .clr(start), .add(add), .cur(cur),
      .pred(pred), .refc(ref_code), .sum_test(sum_test), .sum_ref(sum_ref),
      .win_last(win_last)
   );

   tiskew_divider #(.DVD_W(DVD_W), .DSR_W(SUM_W)) i_div (
      .clk(clk), .rst_n(rst_n), .abort(start), .go(div_go),
      .dividend({sum_test, {FRAC_W{1'b0}}}), .divisor(sum_ref),
      .quot(quot), .done(div_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sel_q     <= '0;
         est_valid <= 1'b0;
         est_err   <= 1'b0;
         est_value <= '0;
      end else begin
         est_valid <= 1'b0;
         est_err   <= 1'b0;
         if (start) begin
            state_q <= ST_ACC;
            sel_q   <= sel_idx;
         end else begin
            case (state_q)
               ST_ACC: if (win_last) state_q <= ST_LOAD;
               ST_LOAD: begin
                  if (sum_ref == '0) begin
                     est_valid <= 1'b1;
                     est_err   <= 1'b1;
                     est_value <= '0;
                     state_q   <= ST_IDLE;
                  end else begin
                     state_q <= ST_DIV;
                  end
               end
               ST_DIV: if (div_done) begin
                  est_valid <= 1'b1;
                  est_value <= ONE - {1'b0, quot};
                  state_q   <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      est_valid |=> !est_valid) else $error("valid held"); // R6
   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      est_err |-> (est_valid && est_value == '0)) else $error("error without zero result"); // R7
   AST_START_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !est_valid) else $error("result after restart"); // R8
   AST_IDLE_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_ACC) |-> !add) else $error("frame counted outside window"); // R4
endmodule

// File: tb/test_tiskew_estimator.sv
module test_tiskew_estimator;
   localparam int CLK_PER  = 10;
   localparam int CODE_W   = 8;
   localparam int NCH      = 4;
   localparam int WIN_LOG2 = 4;
   localparam int FRAC_W   = 12;
   localparam int WIN      = 1 << WIN_LOG2;
   localparam int DVD_W    = CODE_W + WIN_LOG2 + FRAC_W;
   localparam int OUT_W    = DVD_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] sel_idx = '0;
   logic frame_valid = 1'b0;
   logic [NCH*CODE_W-1:0] ch_codes = '0;
   logic [CODE_W-1:0] ref_code = '0;
   logic est_valid, est_err;
   logic [OUT_W-1:0] est_value;

   int checks = 0, failures = 0, cycles = 0;
   int lane_v [NCH];
   int ref_v;
   // behavioural model
   bit m_open = 0, m_have = 0, pending = 0;
   int m_sel = 0, m_prev = 0, m_cnt = 0, wait_cnt = 0;
   longint sum_a = 0, sum_b = 0, exp_val = 0, last_val = 0;
   bit exp_err = 0;

   always #(CLK_PER/2) clk = ~clk;

   tiskew_estimator #(.CODE_W(CODE_W), .NCH(NCH), .WIN_LOG2(WIN_LOG2), .FRAC_W(FRAC_W)) i_tiskew_estimator (
      .clk(clk), .rst_n(rst_n), .start(start), .sel_idx(sel_idx),
      .frame_valid(frame_valid), .ch_codes(ch_codes), .ref_code(ref_code),
      .est_valid(est_valid), .est_value(est_value), .est_err(est_err)
   );

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic send(input bit v);
      @(negedge clk);
      start = 1'b0;
      frame_valid = v;
      for (int i = 0; i < NCH; i++) ch_codes[i*CODE_W +: CODE_W] = CODE_W'(lane_v[i]);
      ref_code = CODE_W'(ref_v);
      if (v && m_open) begin
         bit use_it;
         int pr;
         if (m_sel != 0) begin use_it = 1; pr = lane_v[m_sel-1]; end
         else begin use_it = m_have; pr = m_prev; end
         m_have = 1;
         m_prev = lane_v[NCH-1];
         if (use_it) begin
            sum_a += absd(lane_v[m_sel], pr);
            sum_b += absd(ref_v, pr);
            m_cnt++;
            if (m_cnt == WIN) begin
               m_open = 0;
               pending = 1;
               wait_cnt = 0;
               if (sum_b == 0) begin exp_err = 1; exp_val = 0; end
               else begin
                  exp_err = 0;
                  exp_val = (longint'(1) <<< FRAC_W) - ((sum_a <<< FRAC_W) / sum_b);
               end
            end
         end
      end
   endtask

   task automatic begin_win(input int s);
      @(negedge clk);
      start = 1'b1;
      frame_valid = 1'b0;
      sel_idx = 2'(s);
      m_sel = s; m_open = 1; m_have = 0; m_cnt = 0; sum_a = 0; sum_b = 0; pending = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(1'b0);
   endtask

   task automatic wait_result();
      while (pending) @(posedge clk);
      #3;
   endtask

   // pattern: lanes follow a ramp; ref = selected lane + ofs
   task automatic fill(input int k, input int s, input int ofs);
      for (int i = 0; i < NCH; i++) lane_v[i] = (k*29 + i*41 + 7) % 200 + 20;
      ref_v = lane_v[s] + ofs;
   endtask

   always @(posedge clk) begin
      #2;
      cycles++;
      if (rst_n) begin
         if (pending) begin
            wait_cnt++;
            if (est_valid) begin
               check($signed(est_value) == exp_val, "R5 value", $signed(est_value), exp_val);
               check(est_err == exp_err, "R7 err", est_err, exp_err);
               last_val = $signed(est_value);
               pending = 0;
            end else if (wait_cnt > DVD_W + 4) begin
               check(0, "R6 latency", wait_cnt, DVD_W + 4);
               pending = 0;
            end
         end else begin
            check(!est_valid, "R6/R8 no unexpected pulse", est_valid, 0);
         end
      end
      if (cycles > 100000) begin
         check(0, "watchdog", cycles, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) lane_v[i] = 0;
      ref_v = 0;
      repeat (3) @(negedge clk);
      #1;
      check(!est_valid && !est_err && est_value == '0, "R1 reset", est_value, 0);
      rst_n = 1'b1;

      // R2: index 2, reference slightly ahead of the test channel
      begin_win(2);
      for (int k = 0; k < WIN; k++) begin fill(k, 2, 3); send(1); end
      idle(1); wait_result();

      // R3: index 0 uses the previous frame's last lane; first frame ignored
      begin_win(0);
      for (int k = 0; k < WIN + 1; k++) begin fill(k, 0, -2); send(1); end
      idle(1); wait_result();

      // R5: equal steps -> exactly zero
      begin_win(1);
      for (int k = 0; k < WIN; k++) begin fill(k, 1, 0); send(1); end
      idle(1); wait_result();
      check(last_val == 0, "R5 equal sums", last_val, 0);

      // R7: reference always equals predecessor -> error
      begin_win(3);
      for (int k = 0; k < WIN; k++) begin fill(k, 3, 0); ref_v = lane_v[2]; send(1); end
      idle(1); wait_result();

      // R4: gaps inside window, frames outside any window
      begin_win(1);
      for (int k = 0; k < WIN; k++) begin
         fill(k, 1, 5); send(1);
         fill(k + 50, 1, 90); send(0);
      end
      idle(1); wait_result();
      for (int k = 0; k < 6; k++) begin fill(k, 1, 40); send(1); end
      idle(DVD_W + 8);

      // R9: test channel steps larger than reference -> negative
      begin_win(2);
      for (int k = 0; k < WIN; k++) begin
         fill(k, 2, 0); lane_v[1] = 100; lane_v[2] = 160; ref_v = 120; send(1);
      end
      idle(1); wait_result();
      check(last_val < 0, "R9 negative sign", last_val, -1);

      // R8: restart during division drops old window
      begin_win(1);
      for (int k = 0; k < WIN; k++) begin fill(k, 1, 7); send(1); end
      idle(5);
      begin_win(2);
      for (int k = 0; k < WIN; k++) begin fill(k + 3, 2, -4); send(1); end
      idle(1); wait_result();

      // R10: full-scale steps
      begin_win(1);
      for (int k = 0; k < WIN; k++) begin
         fill(k, 1, 0); lane_v[0] = 0; lane_v[1] = 255; ref_v = 1; send(1);
      end
      idle(1); wait_result();
      check(last_val == -1040384, "R10 full scale", last_val, -1040384);

      idle(4);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule